// File: doc/BRIEF.md
# Packed Lane SIMD Adder

This unit performs lane-parallel integer arithmetic on two 32-bit words. It can split the words into two signed 16-bit halves or four signed 8-bit bytes. An operation class and an operation code select the work. The halfword work covers four operations: add, subtract, and two crossed forms that pair each half of A with the opposite half of B. Each can wrap or saturate. The byte work covers signed add and signed subtract, and it also produces one greater-or-equal flag per byte. A third class clamps each signed halfword of A to a signed range whose width is programmable.

A request is presented with `in_valid` high and is registered on the next rising clock edge. The result, the flags, the illegal-operation indication and a one-cycle `out_valid` pulse are therefore available one cycle after the request. The registered outputs keep their values while no request is presented.

Top module: `packed_simd_adder`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `res_o`, `ge_o` and `illegal_o` are all zero.
- R2: A request sampled with `in_valid` high updates the outputs at that clock edge and raises `out_valid` for exactly that one cycle. When `in_valid` is low, `out_valid` is 0 and `res_o`, `ge_o` and `illegal_o` keep their values.
- R3: With class 2'b00 (wrapping), code 8'hF1 gives lane-wise halfword sums and code 8'hF7 gives lane-wise halfword differences (A minus B). The result is packed as {high lane[15:0], low lane[15:0]}, and only the low 16 bits of each lane are kept.
- R4: Code 8'hF3 gives low = A[15:0] − B[31:16] and high = A[31:16] + B[15:0]. Code 8'hF5 gives low = A[15:0] + B[31:16] and high = A[31:16] − B[15:0]. These are the crossed forms, and they are available in both class 2'b00 and class 2'b01.
- R5: Class 2'b01 (saturating) accepts codes 8'hF1, 8'hF3, 8'hF5 and 8'hF7 with the pairings of R3 and R4. It clamps each signed lane result to −0x8000..0x7FFF before packing.
- R6: With class 2'b00, code 8'hF9 adds the four signed bytes and code 8'hFF subtracts them (A minus B). Each byte result is truncated to 8 bits, and byte lane k sits in bits [8k+7:8k].
- R7: A byte operation sets `ge_o[k]` to 1 exactly when the full-precision 9-bit signed result of byte lane k is greater than or equal to zero.
- R8: Any accepted request other than a byte operation leaves `ge_o` unchanged.
- R9: Class 2'b10 ignores the code and B. It clamps each signed halfword of A to −2^w..2^w−1, where w is `sat_width` (so the width is n = w+1 bits), and packs the two lanes as in R3.
- R10: Any request that is not recognised sets `illegal_o` to 1 and `res_o` to zero, and leaves `ge_o` unchanged. This covers class 2'b11, and any code outside {F1,F3,F5,F7,F9,FF} in class 2'b00 or outside {F1,F3,F5,F7} in class 2'b01. Any recognised request clears `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_class | input | 2 | 00 wrap, 01 saturate, 10 width clamp, 11 reserved |
| op_code | input | 8 | Operation code within the class |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sat_width | input | 4 | Clamp width minus one, for class 10 |
| out_valid | output | 1 | One-cycle pulse: outputs were just updated |
| res_o | output | 32 | Packed lane result |
| ge_o | output | 4 | Per-byte greater-or-equal flags, bit k for byte lane k |
| illegal_o | output | 1 | Last request was not recognised |

## Verification
The only state the unit holds is its output registers and the flag vector. A wrong flag update therefore cannot appear in the result of the request that caused it. It shows up one cycle later as a stale or altered `ge_o`, and it stays visible through every following halfword or illegal request, until the next byte operation overwrites it. A decode fault that mixes up the crossed pairings or the saturation selection appears in `res_o` on the very next cycle. It is exposed only when the operand halves differ and the lanes reach their limits, which is why the stimulus places 0x7FFF, 0x8000, 0x7F and 0x80 in every lane.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int WORD_W  = 32;
    localparam int N_HALF  = 2;
    localparam int N_BYTE  = 4;
    localparam int HALF_W  = WORD_W / N_HALF;
    localparam int BYTE_W  = WORD_W / N_BYTE;
    localparam int SATW_W  = 4;
    localparam int CODE_W  = 8;

    localparam logic [CODE_W-1:0] CODE_HADD = 8'hF1;
    localparam logic [CODE_W-1:0] CODE_HASX = 8'hF3;
    localparam logic [CODE_W-1:0] CODE_HSAX = 8'hF5;
    localparam logic [CODE_W-1:0] CODE_HSUB = 8'hF7;
    localparam logic [CODE_W-1:0] CODE_BADD = 8'hF9;
    localparam logic [CODE_W-1:0] CODE_BSUB = 8'hFF;

    typedef enum logic [1:0] {
        CLS_WRAP  = 2'b00,
        CLS_QSAT  = 2'b01,
        CLS_CLAMP = 2'b10,
        CLS_RSVD  = 2'b11
    } op_class_e;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_HADD  = 3'd1,
        K_HASX  = 3'd2,
        K_HSAX  = 3'd3,
        K_HSUB  = 3'd4,
        K_BADD  = 3'd5,
        K_BSUB  = 3'd6,
        K_CLAMP = 3'd7
    } op_kind_e;

    // Clamp a (HALF_W+1)-bit signed value to the HALF_W-bit signed range.
    function automatic logic [HALF_W-1:0] sat_half(input logic [HALF_W:0] v);
        if (v[HALF_W] != v[HALF_W-1])
            return {v[HALF_W], {(HALF_W-1){~v[HALF_W]}}};
        else
            return v[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/simd_op_decode.sv
module simd_op_decode
    import simd_pkg::*;
(
    input  logic [1:0]        op_class,
    input  logic [CODE_W-1:0] op_code,
    output op_kind_e          kind_o,
    output logic              sat_o
);

    op_kind_e half_kind;

    // Halfword operation codes are shared by the wrapping and saturating classes.
    always_comb begin
        unique case (op_code)
            CODE_HADD: half_kind = K_HADD;
            CODE_HASX: half_kind = K_HASX;
            CODE_HSAX: half_kind = K_HSAX;
            CODE_HSUB: half_kind = K_HSUB;
            default:   half_kind = K_NONE;
        endcase
    end

    always_comb begin
        kind_o = K_NONE;
        sat_o  = 1'b0;
        unique case (op_class_e'(op_class))
            CLS_WRAP: begin
                if (op_code == CODE_BADD)
                    kind_o = K_BADD;
                else if (op_code == CODE_BSUB)
                    kind_o = K_BSUB;
                else
                    kind_o = half_kind;
            end
            CLS_QSAT: begin
                kind_o = half_kind;
                sat_o  = 1'b1;
            end
            CLS_CLAMP: kind_o = K_CLAMP;
            CLS_RSVD:  kind_o = K_NONE;
        endcase
    end

endmodule

// File: rtl/simd_half_lanes.sv
module simd_half_lanes
    import simd_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  op_kind_e          kind_i,
    input  logic              sat_i,
    output logic [WORD_W-1:0] res_o
);

    logic xchg;
    assign xchg = (kind_i == K_HASX) || (kind_i == K_HSAX);

    for (genvar i = 0; i < N_HALF; i++) begin : g_lane
        localparam int PART = N_HALF - 1 - i;

        logic              lane_sub;
        logic [HALF_W-1:0] b_sel;
        logic [HALF_W:0]   ea;
        logic [HALF_W:0]   eb;
        logic [HALF_W:0]   sum;

        always_comb begin
            unique case (kind_i)
                K_HSUB:  lane_sub = 1'b1;
                K_HASX:  lane_sub = (i == 0);
                K_HSAX:  lane_sub = (i != 0);
                default: lane_sub = 1'b0;
            endcase
        end

        assign b_sel = xchg ? b_i[PART*HALF_W +: HALF_W] : b_i[i*HALF_W +: HALF_W];
        assign ea    = {a_i[i*HALF_W+HALF_W-1], a_i[i*HALF_W +: HALF_W]};
        assign eb    = {b_sel[HALF_W-1], b_sel};
        assign sum   = lane_sub ? (ea - eb) : (ea + eb);

        assign res_o[i*HALF_W +: HALF_W] = sat_i ? sat_half(sum) : sum[HALF_W-1:0];
    end

endmodule

// File: rtl/simd_byte_lanes.sv
module simd_byte_lanes
    import simd_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              sub_i,
    output logic [WORD_W-1:0] res_o,
    output logic [N_BYTE-1:0] ge_o
);

    for (genvar k = 0; k < N_BYTE; k++) begin : g_lane
        logic [BYTE_W-1:0] ab;
        logic [BYTE_W-1:0] bb;
        logic [BYTE_W:0]   sum;

        assign ab  = a_i[k*BYTE_W +: BYTE_W];
        assign bb  = b_i[k*BYTE_W +: BYTE_W];
        assign sum = sub_i ? ({ab[BYTE_W-1], ab} - {bb[BYTE_W-1], bb})
                           : ({ab[BYTE_W-1], ab} + {bb[BYTE_W-1], bb});

        assign res_o[k*BYTE_W +: BYTE_W] = sum[BYTE_W-1:0];
        // The full-precision result cannot overflow, so its sign bit decides.
        assign ge_o[k] = ~sum[BYTE_W];
    end

endmodule

// File: rtl/simd_width_clamp.sv
module simd_width_clamp
    import simd_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [SATW_W-1:0] width_i,
    output logic [WORD_W-1:0] res_o
);

    logic signed [HALF_W:0] lim_hi;
    logic signed [HALF_W:0] lim_lo;

    // Upper bound 2^w - 1; the lower bound -2^w is its bitwise complement.
    assign lim_hi = $signed((HALF_W+1)'(1) << width_i) - $signed((HALF_W+1)'(1));
    assign lim_lo = ~lim_hi;

    for (genvar i = 0; i < N_HALF; i++) begin : g_lane
        logic signed [HALF_W:0] val;

        assign val = $signed({a_i[i*HALF_W+HALF_W-1], a_i[i*HALF_W +: HALF_W]});

        always_comb begin
            if (val > lim_hi)
                res_o[i*HALF_W +: HALF_W] = lim_hi[HALF_W-1:0];
            else if (val < lim_lo)
                res_o[i*HALF_W +: HALF_W] = lim_lo[HALF_W-1:0];
            else
                res_o[i*HALF_W +: HALF_W] = val[HALF_W-1:0];
        end
    end

endmodule

// File: rtl/packed_simd_adder.sv
module packed_simd_adder
    import simd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_class,
    input  logic [CODE_W-1:0] op_code,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic [SATW_W-1:0] sat_width,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_o,
    output logic [N_BYTE-1:0] ge_o,
    output logic              illegal_o
);

    op_kind_e          kind;
    logic              sat_en;
    logic [WORD_W-1:0] half_res;
    logic [WORD_W-1:0] byte_res;
    logic [N_BYTE-1:0] byte_ge;
    logic [WORD_W-1:0] clamp_res;

    logic [WORD_W-1:0] res_d;
    logic [N_BYTE-1:0] ge_d;
    logic              ill_d;

    simd_op_decode u_dec (
        .op_class (op_class),
        .op_code  (op_code),
        .kind_o   (kind),
        .sat_o    (sat_en)
    );

    simd_half_lanes u_half (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .kind_i (kind),
        .sat_i  (sat_en),
        .res_o  (half_res)
    );

    simd_byte_lanes u_byte (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .sub_i (kind == K_BSUB),
        .res_o (byte_res),
        .ge_o  (byte_ge)
    );

    simd_width_clamp u_clamp (
        .a_i     (opnd_a),
        .width_i (sat_width),
        .res_o   (clamp_res)
    );

    // Next-value selection.
    always_comb begin
        res_d = res_o;
        ge_d  = ge_o;
        ill_d = illegal_o;
        if (in_valid) begin
            ill_d = 1'b0;
            unique case (kind)
                K_NONE: begin
                    res_d = '0;
                    ill_d = 1'b1;
                end
                K_BADD, K_BSUB: begin
                    res_d = byte_res;
                    ge_d  = byte_ge;
                end
                K_CLAMP: res_d = clamp_res;
                K_HADD, K_HASX, K_HSAX, K_HSUB: res_d = half_res;
            endcase
        end
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_o     <= '0;
            ge_o      <= '0;
            illegal_o <= 1'b0;
        end else begin
            out_valid <= in_valid;
            res_o     <= res_d;
            ge_o      <= ge_d;
            illegal_o <= ill_d;
        end
    end

endmodule

// File: rtl/simd_adder_checker.sv
module simd_adder_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  op_class,
    input logic [7:0]  op_code,
    input logic [3:0]  sat_width,
    input logic        out_valid,
    input logic [31:0] res_o,
    input logic [3:0]  ge_o,
    input logic        illegal_o
);

    logic byte_req;
    assign byte_req = (op_class == 2'b00) && (op_code == 8'hF9 || op_code == 8'hFF);

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                           // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_o) && $stable(ge_o) && $stable(illegal_o))); // R2

    AST_GE_KEPT_NONBYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !byte_req) |=> $stable(ge_o));                        // R8

    AST_ILLEGAL_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (res_o == 32'h0));                                   // R10

    AST_RESERVED_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 2'b11) |=> illegal_o);                    // R10

    AST_CLAMP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 2'b10) |=>
            ($signed({res_o[31], res_o[31:16]}) <= $signed((17'd1 << $past(sat_width)) - 17'd1)) &&
            ($signed({res_o[15], res_o[15:0]})  <= $signed((17'd1 << $past(sat_width)) - 17'd1))); // R9

    AST_CLAMP_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 2'b10) |=>
            ($signed({res_o[31], res_o[31:16]}) >= -$signed(17'd1 << $past(sat_width))) &&
            ($signed({res_o[15], res_o[15:0]})  >= -$signed(17'd1 << $past(sat_width))));  // R9

endmodule

bind packed_simd_adder simd_adder_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_class  (op_class),
    .op_code   (op_code),
    .sat_width (sat_width),
    .out_valid (out_valid),
    .res_o     (res_o),
    .ge_o      (ge_o),
    .illegal_o (illegal_o)
);

// File: tb/sim_packed_simd_adder.sv
`timescale 1ns/1ps
module sim_packed_simd_adder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_class = '0;
    logic [7:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  sat_width = '0;
    logic        out_valid;
    logic [31:0] res_o;
    logic [3:0]  ge_o;
    logic        illegal_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] model_ge = '0;

    always #4 clk = ~clk;

    packed_simd_adder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
        .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_width(sat_width),
        .out_valid(out_valid), .res_o(res_o), .ge_o(ge_o), .illegal_o(illegal_o)
    );

    // {class, code, a, b, width, expected result, expected ge, expected illegal}
    localparam int NV = 15;
    localparam logic [114:0] VEC [NV] = '{
        {2'd0, 8'hF1, 32'h7FFF0001, 32'h0001FFFF, 4'd0,  32'h80000000, 4'b0000, 1'b0},
        {2'd1, 8'hF1, 32'h7FFF0001, 32'h0001FFFF, 4'd0,  32'h7FFF0000, 4'b0000, 1'b0},
        {2'd0, 8'hF3, 32'h00050003, 32'h00020007, 4'd0,  32'h000C0001, 4'b0000, 1'b0},
        {2'd0, 8'hF5, 32'h00050003, 32'h00020007, 4'd0,  32'hFFFE0005, 4'b0000, 1'b0},
        {2'd1, 8'hF7, 32'h80007FFF, 32'h0001FFFF, 4'd0,  32'h80007FFF, 4'b0000, 1'b0},
        {2'd0, 8'hF9, 32'h7F800110, 32'h0180FFF0, 4'd0,  32'h80000000, 4'b1011, 1'b0},
        {2'd0, 8'hF7, 32'h00000000, 32'h00010001, 4'd0,  32'hFFFFFFFF, 4'b1011, 1'b0},
        {2'd0, 8'hFF, 32'h807F0005, 32'h7F800005, 4'd0,  32'h01FF0000, 4'b0111, 1'b0},
        {2'd2, 8'h00, 32'h0100FF00, 32'h12345678, 4'd7,  32'h007FFF80, 4'b0111, 1'b0},
        {2'd2, 8'h55, 32'h80007FFF, 32'h00000000, 4'd15, 32'h80007FFF, 4'b0111, 1'b0},
        {2'd2, 8'hF1, 32'h0005FFFB, 32'hFFFFFFFF, 4'd0,  32'h0000FFFF, 4'b0111, 1'b0},
        {2'd0, 8'h12, 32'h11111111, 32'h22222222, 4'd0,  32'h00000000, 4'b0111, 1'b1},
        {2'd3, 8'hF1, 32'h00010001, 32'h00010001, 4'd0,  32'h00000000, 4'b0111, 1'b1},
        {2'd1, 8'hF9, 32'h01010101, 32'h01010101, 4'd0,  32'h00000000, 4'b0111, 1'b1},
        {2'd0, 8'hF1, 32'h00000001, 32'h00000002, 4'd0,  32'h00000003, 4'b0111, 1'b0}
    };

    function automatic string tag_of(input logic [1:0] c, input logic [7:0] k);
        if (c == 2'd3) return "R10";
        if (c == 2'd2) return "R9";
        if (c == 2'd1) return (k == 8'hF1 || k == 8'hF3 || k == 8'hF5 || k == 8'hF7) ? "R5" : "R10";
        if (k == 8'hF1 || k == 8'hF7) return "R3";
        if (k == 8'hF3 || k == 8'hF5) return "R4";
        if (k == 8'hF9 || k == 8'hFF) return "R6";
        return "R10";
    endfunction

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    // Reference model written from the requirements.
    function automatic void ref_op(input logic [1:0] c, input logic [7:0] k,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [3:0] w, input logic [3:0] gin,
                                   output logic [31:0] r, output logic [3:0] g,
                                   output logic il);
        int al, ah, bl, bh, r0, r1, lim, x, y, s;
        al = int'($signed(a[15:0]));  ah = int'($signed(a[31:16]));
        bl = int'($signed(b[15:0]));  bh = int'($signed(b[31:16]));
        r = '0; g = gin; il = 1'b0; r0 = 0; r1 = 0;
        if (c == 2'd3) begin
            il = 1'b1;
        end else if (c == 2'd2) begin
            lim = 1 << w;
            r0 = clampi(al, -lim, lim - 1);
            r1 = clampi(ah, -lim, lim - 1);
            r = {16'(r1), 16'(r0)};
        end else if (c == 2'd0 && (k == 8'hF9 || k == 8'hFF)) begin
            for (int j = 0; j < 4; j++) begin
                x = int'($signed(a[8*j +: 8]));
                y = int'($signed(b[8*j +: 8]));
                s = (k == 8'hF9) ? x + y : x - y;
                r[8*j +: 8] = 8'(s);
                g[j] = (s >= 0);
            end
        end else if (k == 8'hF1 || k == 8'hF3 || k == 8'hF5 || k == 8'hF7) begin
            case (k)
                8'hF1:   begin r0 = al + bl; r1 = ah + bh; end
                8'hF3:   begin r0 = al - bh; r1 = ah + bl; end
                8'hF5:   begin r0 = al + bh; r1 = ah - bl; end
                default: begin r0 = al - bl; r1 = ah - bh; end
            endcase
            if (c == 2'd1) begin
                r0 = clampi(r0, -32768, 32767);
                r1 = clampi(r1, -32768, 32767);
            end
            r = {16'(r1), 16'(r0)};
        end else begin
            il = 1'b1;
        end
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] c, input logic [7:0] k,
                          input logic [31:0] a, input logic [31:0] b, input logic [3:0] w,
                          input logic [31:0] er, input logic [3:0] eg, input logic ei);
        string t;
        t = tag_of(c, k);
        @(negedge clk);
        op_class = c; op_code = k; opnd_a = a; opnd_b = b; sat_width = w; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, "R2", "out_valid", {31'd0, out_valid}, 32'd1);
        chk(res_o === er, t, "result", res_o, er);
        chk(ge_o === eg, (c == 2'd0 && (k == 8'hF9 || k == 8'hFF)) ? "R7" : "R8",
            "ge", {28'd0, ge_o}, {28'd0, eg});
        chk(illegal_o === ei, "R10", "illegal", {31'd0, illegal_o}, {31'd0, ei});
        model_ge = eg;
    endtask

    task automatic run_ref(input logic [1:0] c, input logic [7:0] k,
                           input logic [31:0] a, input logic [31:0] b, input logic [3:0] w);
        logic [31:0] er; logic [3:0] eg; logic ei;
        ref_op(c, k, a, b, w, model_ge, er, eg, ei);
        run_op(c, k, a, b, w, er, eg, ei);
    endtask

    localparam logic [31:0] CORNER [6] = '{
        32'h7FFF8000, 32'h80007FFF, 32'h7F80807F, 32'h807F7F80, 32'h7FFF7FFF, 32'h80008000
    };
    localparam logic [9:0] OPS [10] = '{
        {2'd0, 8'hF1}, {2'd0, 8'hF3}, {2'd0, 8'hF5}, {2'd0, 8'hF7}, {2'd0, 8'hF9},
        {2'd0, 8'hFF}, {2'd1, 8'hF1}, {2'd1, 8'hF3}, {2'd1, 8'hF5}, {2'd1, 8'hF7}
    };
    localparam logic [7:0] CODES [8] = '{8'hF1, 8'hF3, 8'hF5, 8'hF7, 8'hF9, 8'hFF, 8'h12, 8'h00};

    initial begin
        logic [31:0] hold_r; logic [3:0] hold_g; logic hold_i;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1", "out_valid", {31'd0, out_valid}, 32'd0);
        chk(res_o === 32'd0, "R1", "result", res_o, 32'd0);
        chk(ge_o === 4'd0, "R1", "ge", {28'd0, ge_o}, 32'd0);
        chk(illegal_o === 1'b0, "R1", "illegal", {31'd0, illegal_o}, 32'd0);
        rst_n = 1'b1;

        // Table of directed vectors
        for (int v = 0; v < NV; v++)
            run_op(VEC[v][114:113], VEC[v][112:105], VEC[v][104:73], VEC[v][72:41],
                   VEC[v][40:37], VEC[v][36:5], VEC[v][4:1], VEC[v][0]);

        // R2: outputs hold while idle even though the inputs change
        hold_r = res_o; hold_g = ge_o; hold_i = illegal_o;
        @(negedge clk);
        op_class = 2'd0; op_code = 8'hFF; opnd_a = 32'h80808080; opnd_b = 32'h7F7F7F7F;
        repeat (2) @(negedge clk);
        chk(out_valid === 1'b0, "R2", "idle out_valid", {31'd0, out_valid}, 32'd0);
        chk(res_o === hold_r, "R2", "idle result", res_o, hold_r);
        chk(ge_o === hold_g, "R2", "idle ge", {28'd0, ge_o}, {28'd0, hold_g});
        chk(illegal_o === hold_i, "R2", "idle illegal", {31'd0, illegal_o}, {31'd0, hold_i});

        // Corner values in every lane, all lane operations
        for (int pa = 0; pa < 6; pa++)
            for (int pb = 0; pb < 6; pb++)
                for (int o = 0; o < 10; o++)
                    run_ref(OPS[o][9:8], OPS[o][7:0], CORNER[pa], CORNER[pb], 4'd0);
        for (int pa = 0; pa < 6; pa++) begin
            run_ref(2'd2, 8'h00, CORNER[pa], 32'h0, 4'd0);
            run_ref(2'd2, 8'h00, CORNER[pa], 32'h0, 4'd7);
            run_ref(2'd2, 8'h00, CORNER[pa], 32'h0, 4'd15);
        end

        // Random operands, classes and codes (illegal included)
        for (int n = 0; n < 400; n++)
            run_ref(2'($urandom_range(0, 3)), CODES[$urandom_range(0, 7)],
                    $urandom, $urandom, 4'($urandom_range(0, 15)));

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(res_o === 32'd0 && ge_o === 4'd0 && illegal_o === 1'b0 && out_valid === 1'b0,
            "R1", "mid-run reset", res_o, 32'd0);
        rst_n = 1'b1;
        model_ge = '0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule